// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block judges whether a pending interrupt at a given priority level is accepted and, when it is, performs the processor state updates that interrupt entry needs. On each request cycle it receives the pending level and the current effective interrupt level. It also receives a per-level mask table, the set and enable interrupt vectors, the status word, the current PC, a vector-base value and a flag saying whether a separate double-exception PC register exists. One clock later it presents the new status word, the new PC, an entry class and a one-cycle taken strobe. It also owns the saved-PC, saved-status, double-exception PC and exception-cause registers that entry writes.

Levels above 1 are vectored directly. The PC and status word are saved in that level's registers, the status level field is raised to the taken level, and control moves to the level's vector. A level-1 interrupt is not vectored on its own. It is turned into a kernel, user or double exception depending on the status bits, and records a fixed cause code. Vector addresses are offsets from a base. That base is either the fixed default base or, when relocation is enabled, the live vector-base input.

Top module: `intc_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when `req_i` is high, `pend_level_i` is strictly greater than `cur_level_i`, `pend_level_i` is no greater than NLEVEL (6), and the mask word of that level (bits `(L-1)*NINT +: NINT` of `level_mask_i`) ANDed with `intset_i` and `inten_i` is nonzero.
- R2: When no interrupt is taken, no output register changes: `ps_o`, `pc_o`, `class_o`, `exccause_o`, `epc_o`, `eps_o` and `depc_o` hold their values.
- R3: `taken_o` is high for exactly the one cycle after each request that is taken, and is low after reset.
- R4: For a taken level L above 1, the saved-PC slot of level L (`epc_o[(L-1)*32 +: 32]`) receives `pc_i`, and the saved-status slot of level L (`eps_o[(L-2)*32 +: 32]`) receives `ps_i`. No other save register changes.
- R5: For a taken level L above 1, `ps_o` equals `ps_i` with bits [3:0] (interrupt level) replaced by L and bit 4 (exception mode) set, and `class_o` is 1 (high-level).
- R6: For a taken level-1 interrupt, `exccause_o` becomes 4, and `ps_o` equals `ps_i` with bit 4 set and all other bits unchanged.
- R7: For a taken level-1 interrupt with `ps_i` bit 4 already set, `class_o` is 4 (double). `pc_i` is saved into `depc_o` when `has_depc_i` is high, and otherwise into the level-1 saved-PC slot (`epc_o[31:0]`).
- R8: For a taken level-1 interrupt with `ps_i` bit 4 clear, `pc_i` is saved into the level-1 saved-PC slot. `class_o` is 3 (user) when `ps_i` bit 5 is set, and 2 (kernel) when it is clear.
- R9: With relocation enabled, `pc_o` after a take is `vecbase_i` plus the class offset. The offset is L*0x40 for high levels, 0x300 for kernel, 0x340 for user and 0x3C0 for double, which is the configured vector minus the default base plus the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Evaluate the pending interrupt this cycle |
| pend_level_i | input | 3 | Pending interrupt level |
| cur_level_i | input | 3 | Current effective interrupt level |
| level_mask_i | input | 96 | Per-level interrupt masks, level L in slice L-1 |
| intset_i | input | 16 | Raised interrupt lines |
| inten_i | input | 16 | Enabled interrupt lines |
| ps_i | input | 32 | Status word before entry |
| pc_i | input | 32 | PC to be saved |
| vecbase_i | input | 32 | Vector-base register value |
| has_depc_i | input | 1 | A double-exception PC register exists |
| ps_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Entry vector address |
| class_o | output | 3 | Entry class: 1 high, 2 kernel, 3 user, 4 double |
| exccause_o | output | 8 | Exception cause register |
| epc_o | output | 192 | Saved-PC registers, levels 1..6 |
| eps_o | output | 160 | Saved-status registers, levels 2..6 |
| depc_o | output | 32 | Double-exception PC register |
| taken_o | output | 1 | One-cycle taken strobe |

## Verification
The assertions assume the environment holds `cur_level_i` at or above the status level field, so a high-level take always leaves `ps_o[3:0]` above the sampled current level. They also assume the inputs are settled with `req_i` for one full cycle. The stimulus draws levels over the whole 3-bit range, including values above NLEVEL, and varies `req_i`, masks, set and enable words, the status bits and the double-PC flag. It drives everything at the falling edge, so each request is stable at the capturing edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_HIGH   = 3'd1,
    CLS_KERNEL = 3'd2,
    CLS_USER   = 3'd3,
    CLS_DOUBLE = 3'd4
  } entry_cls_e;

  localparam int unsigned PS_LVL_W     = 4;
  localparam int unsigned PS_EXCM_BIT  = 4;
  localparam int unsigned PS_UM_BIT    = 5;
  localparam int unsigned CAUSE_W      = 8;
  localparam logic [7:0]  CAUSE_LEVEL1 = 8'd4;
endpackage

// File: rtl/intc_take_eval.sv
module intc_take_eval
  import intc_pkg::*;
#(
  parameter int unsigned NLEVEL = 6,
  parameter int unsigned NINT   = 16,
  parameter int unsigned XLEN   = 32,
  localparam int unsigned LW    = $clog2(NLEVEL + 1)
) (
  input  logic                   req,
  input  logic [LW-1:0]          pend,
  input  logic [LW-1:0]          cur,
  input  logic [NLEVEL*NINT-1:0] mask_tbl,
  input  logic [NINT-1:0]        intset,
  input  logic [NINT-1:0]        inten,
  input  logic [XLEN-1:0]        ps,
  input  logic                   has_depc,
  output logic                   take,
  output entry_cls_e             cls,
  output logic [XLEN-1:0]        ps_new,
  output logic [NLEVEL-1:0]      epc_we,
  output logic [NLEVEL-2:0]      eps_we,
  output logic                   depc_we,
  output logic                   cause_we
);
  logic [NINT-1:0] sel_mask;
  logic            lvl_ok;
  logic            high;
  logic            excm;

  always_comb begin
    sel_mask = '0;
    for (int l = 1; l <= int'(NLEVEL); l++) begin
      if (pend == LW'(l)) sel_mask = mask_tbl[(l-1)*NINT +: NINT];
    end
    lvl_ok = (pend > cur) && (int'(pend) <= int'(NLEVEL));
    take   = req && lvl_ok && (|(sel_mask & intset & inten));
    high   = (pend > LW'(1));
    excm   = ps[PS_EXCM_BIT];

    ps_new = ps;
    ps_new[PS_EXCM_BIT] = 1'b1;
    if (high) ps_new[PS_LVL_W-1:0] = PS_LVL_W'(pend);

    if (high)      cls = CLS_HIGH;
    else if (excm) cls = CLS_DOUBLE;
    else if (ps[PS_UM_BIT]) cls = CLS_USER;
    else           cls = CLS_KERNEL;

    for (int l = 1; l <= int'(NLEVEL); l++) begin
      if (l == 1)
        epc_we[0] = take && !high && (!excm || !has_depc);
      else
        epc_we[l-1] = take && high && (pend == LW'(l));
    end
    for (int l = 2; l <= int'(NLEVEL); l++) begin
      eps_we[l-2] = take && high && (pend == LW'(l));
    end
    depc_we  = take && !high && excm && has_depc;
    cause_we = take && !high;
  end
endmodule

// File: rtl/intc_vector_gen.sv
module intc_vector_gen
  import intc_pkg::*;
#(
  parameter int unsigned NLEVEL      = 6,
  parameter int unsigned XLEN        = 32,
  parameter bit          RELOC_EN    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] LVL_STRIDE  = 32'h40,
  parameter logic [31:0] KER_OFF     = 32'h300,
  parameter logic [31:0] USR_OFF     = 32'h340,
  parameter logic [31:0] DBL_OFF     = 32'h3C0,
  localparam int unsigned LW         = $clog2(NLEVEL + 1)
) (
  input  entry_cls_e      cls,
  input  logic [LW-1:0]   level,
  input  logic [XLEN-1:0] vecbase,
  output logic [XLEN-1:0] vec
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  generate
    if (RELOC_EN) begin : g_reloc
      assign base = vecbase;
    end else begin : g_fixed
      assign base = XLEN'(DEF_VECBASE);
    end
  endgenerate

  always_comb begin
    unique case (cls)
      CLS_HIGH:   offset = XLEN'(level) * XLEN'(LVL_STRIDE);
      CLS_KERNEL: offset = XLEN'(KER_OFF);
      CLS_USER:   offset = XLEN'(USR_OFF);
      CLS_DOUBLE: offset = XLEN'(DBL_OFF);
      default:    offset = '0;
    endcase
    vec = base + offset;
  end
endmodule

// File: rtl/intc_save_bank.sv
module intc_save_bank #(
  parameter int unsigned NLEVEL = 6,
  parameter int unsigned XLEN   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLEVEL-1:0]        epc_we,
  input  logic [NLEVEL-2:0]        eps_we,
  input  logic                     depc_we,
  input  logic [XLEN-1:0]          pc_d,
  input  logic [XLEN-1:0]          ps_d,
  output logic [NLEVEL*XLEN-1:0]   epc_q,
  output logic [(NLEVEL-1)*XLEN-1:0] eps_q,
  output logic [XLEN-1:0]          depc_q
);
  genvar g;
  generate
    for (g = 0; g < NLEVEL; g++) begin : g_epc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          epc_q[g*XLEN +: XLEN] <= '0;
        else if (epc_we[g])  epc_q[g*XLEN +: XLEN] <= pc_d;
      end
    end
    for (g = 0; g < NLEVEL-1; g++) begin : g_eps
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          eps_q[g*XLEN +: XLEN] <= '0;
        else if (eps_we[g])  eps_q[g*XLEN +: XLEN] <= ps_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       depc_q <= '0;
    else if (depc_we) depc_q <= pc_d;
  end
endmodule

// File: rtl/intc_entry_ctrl.sv
module intc_entry_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NLEVEL      = 6,
  parameter int unsigned NINT        = 16,
  parameter int unsigned XLEN        = 32,
  parameter bit          RELOC_EN    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  localparam int unsigned LW         = $clog2(NLEVEL + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [LW-1:0]              pend_level_i,
  input  logic [LW-1:0]              cur_level_i,
  input  logic [NLEVEL*NINT-1:0]     level_mask_i,
  input  logic [NINT-1:0]            intset_i,
  input  logic [NINT-1:0]            inten_i,
  input  logic [XLEN-1:0]            ps_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [XLEN-1:0]            vecbase_i,
  input  logic                       has_depc_i,
  output logic [XLEN-1:0]            ps_o,
  output logic [XLEN-1:0]            pc_o,
  output logic [2:0]                 class_o,
  output logic [CAUSE_W-1:0]         exccause_o,
  output logic [NLEVEL*XLEN-1:0]     epc_o,
  output logic [(NLEVEL-1)*XLEN-1:0] eps_o,
  output logic [XLEN-1:0]            depc_o,
  output logic                       taken_o
);
  logic              take;
  entry_cls_e        cls;
  logic [XLEN-1:0]   ps_new;
  logic [XLEN-1:0]   vec;
  logic [NLEVEL-1:0] epc_we;
  logic [NLEVEL-2:0] eps_we;
  logic              depc_we;
  logic              cause_we;

  logic [XLEN-1:0]    ps_q,    ps_d;
  logic [XLEN-1:0]    pc_q,    pc_d;
  entry_cls_e         cls_q,   cls_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               taken_q, taken_d;

  intc_take_eval #(.NLEVEL(NLEVEL), .NINT(NINT), .XLEN(XLEN)) u_eval (
    .req      (req_i),
    .pend     (pend_level_i),
    .cur      (cur_level_i),
    .mask_tbl (level_mask_i),
    .intset   (intset_i),
    .inten    (inten_i),
    .ps       (ps_i),
    .has_depc (has_depc_i),
    .take     (take),
    .cls      (cls),
    .ps_new   (ps_new),
    .epc_we   (epc_we),
    .eps_we   (eps_we),
    .depc_we  (depc_we),
    .cause_we (cause_we)
  );

  intc_vector_gen #(
    .NLEVEL(NLEVEL), .XLEN(XLEN), .RELOC_EN(RELOC_EN), .DEF_VECBASE(DEF_VECBASE)
  ) u_vec (
    .cls     (cls),
    .level   (pend_level_i),
    .vecbase (vecbase_i),
    .vec     (vec)
  );

  intc_save_bank #(.NLEVEL(NLEVEL), .XLEN(XLEN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .epc_we  (epc_we),
    .eps_we  (eps_we),
    .depc_we (depc_we),
    .pc_d    (pc_i),
    .ps_d    (ps_i),
    .epc_q   (epc_o),
    .eps_q   (eps_o),
    .depc_q  (depc_o)
  );

  // next-state
  always_comb begin
    ps_d    = ps_q;
    pc_d    = pc_q;
    cls_d   = cls_q;
    cause_d = cause_q;
    taken_d = take;
    if (take) begin
      ps_d  = ps_new;
      pc_d  = vec;
      cls_d = cls;
    end
    if (cause_we) cause_d = CAUSE_LEVEL1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      pc_q    <= '0;
      cls_q   <= CLS_NONE;
      cause_q <= '0;
      taken_q <= 1'b0;
    end else begin
      ps_q    <= ps_d;
      pc_q    <= pc_d;
      cls_q   <= cls_d;
      cause_q <= cause_d;
      taken_q <= taken_d;
    end
  end

  assign ps_o       = ps_q;
  assign pc_o       = pc_q;
  assign class_o    = cls_q;
  assign exccause_o = cause_q;
  assign taken_o    = taken_q;
endmodule

// File: rtl/intc_entry_ctrl_chk.sv
module intc_entry_ctrl_chk #(
  parameter int unsigned NLEVEL = 6,
  parameter int unsigned XLEN   = 32,
  localparam int unsigned LW    = $clog2(NLEVEL + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_i,
  input logic [LW-1:0]              pend_level_i,
  input logic [LW-1:0]              cur_level_i,
  input logic [XLEN-1:0]            ps_i,
  input logic                       has_depc_i,
  input logic [XLEN-1:0]            ps_o,
  input logic [XLEN-1:0]            pc_o,
  input logic [2:0]                 class_o,
  input logic [7:0]                 exccause_o,
  input logic [NLEVEL*XLEN-1:0]     epc_o,
  input logic [(NLEVEL-1)*XLEN-1:0] eps_o,
  input logic [XLEN-1:0]            depc_o,
  input logic                       taken_o
);
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> ($stable(ps_o) && $stable(pc_o) && $stable(class_o) &&
                  $stable(exccause_o) && $stable(epc_o) && $stable(eps_o) && $stable(depc_o)));

  p_taken_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(req_i));

  p_level_above_cur_r1: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ($past(pend_level_i) > $past(cur_level_i)));

  p_high_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && class_o == 3'd1) |-> (ps_o[3:0] == 4'($past(pend_level_i)) && ps_o[4]));

  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && class_o != 3'd1) |-> (exccause_o == 8'd4 && ps_o[4]));

  p_double_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && class_o == 3'd4) |-> $past(ps_i[4]));

  p_depc_only_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && !$stable(depc_o)) |-> (class_o == 3'd4 && $past(has_depc_i)));

  p_user_kernel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && class_o == 3'd3) |-> ($past(ps_i[5]) && !$past(ps_i[4])));
endmodule

bind intc_entry_ctrl intc_entry_ctrl_chk #(.NLEVEL(NLEVEL), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .pend_level_i (pend_level_i),
  .cur_level_i  (cur_level_i),
  .ps_i         (ps_i),
  .has_depc_i   (has_depc_i),
  .ps_o         (ps_o),
  .pc_o         (pc_o),
  .class_o      (class_o),
  .exccause_o   (exccause_o),
  .epc_o        (epc_o),
  .eps_o        (eps_o),
  .depc_o       (depc_o),
  .taken_o      (taken_o)
);

// File: tb/intc_entry_ctrl_bench.sv
module intc_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;
  localparam int NI = 16;

  logic          clk;
  logic          rst_n;
  logic          req_i;
  logic [2:0]    pend_level_i, cur_level_i;
  logic [NL*NI-1:0] level_mask_i;
  logic [NI-1:0] intset_i, inten_i;
  logic [31:0]   ps_i, pc_i, vecbase_i;
  logic          has_depc_i;
  logic [31:0]   ps_o, pc_o;
  logic [2:0]    class_o;
  logic [7:0]    exccause_o;
  logic [NL*32-1:0]     epc_o;
  logic [(NL-1)*32-1:0] eps_o;
  logic [31:0]   depc_o;
  logic          taken_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ps, m_pc, m_depc;
  logic [2:0]  m_cls;
  logic [7:0]  m_cause;
  logic        m_taken;
  logic [31:0] m_epc [1:NL];
  logic [31:0] m_eps [2:NL];

  intc_entry_ctrl u_intc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .pend_level_i(pend_level_i), .cur_level_i(cur_level_i),
    .level_mask_i(level_mask_i), .intset_i(intset_i), .inten_i(inten_i),
    .ps_i(ps_i), .pc_i(pc_i), .vecbase_i(vecbase_i), .has_depc_i(has_depc_i),
    .ps_o(ps_o), .pc_o(pc_o), .class_o(class_o), .exccause_o(exccause_o),
    .epc_o(epc_o), .eps_o(eps_o), .depc_o(depc_o), .taken_o(taken_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic model_take(input logic rq, input logic [2:0] pend, input logic [2:0] cur,
                                      input logic [NL*NI-1:0] msk, input logic [NI-1:0] st,
                                      input logic [NI-1:0] en);
    logic [NI-1:0] sel;
    sel = '0;
    if (pend >= 3'd1 && pend <= 3'(NL)) sel = msk[(int'(pend)-1)*NI +: NI];
    return rq && (pend > cur) && (pend <= 3'(NL)) && (|(sel & st & en));
  endfunction

  task automatic compare_all(input string tag);
    check({tag, "/R3 taken"}, 32'(taken_o), 32'(m_taken));
    check({tag, "/R5 ps"}, ps_o, m_ps);
    check({tag, "/R9 pc"}, pc_o, m_pc);
    check({tag, "/R8 class"}, 32'(class_o), 32'(m_cls));
    check({tag, "/R6 cause"}, 32'(exccause_o), 32'(m_cause));
    check({tag, "/R7 depc"}, depc_o, m_depc);
    for (int l = 1; l <= NL; l++)
      check($sformatf("%s/R4 epc%0d", tag, l), epc_o[(l-1)*32 +: 32], m_epc[l]);
    for (int l = 2; l <= NL; l++)
      check($sformatf("%s/R4 eps%0d", tag, l), eps_o[(l-2)*32 +: 32], m_eps[l]);
  endtask

  // called at a falling edge; drives one request and checks one cycle later
  task automatic do_req(input string tag, input logic rq, input logic [2:0] pend,
                        input logic [2:0] cur, input logic [NL*NI-1:0] msk,
                        input logic [NI-1:0] st, input logic [NI-1:0] en,
                        input logic [31:0] ps, input logic [31:0] pc,
                        input logic [31:0] vb, input logic hd);
    logic tk;
    req_i = rq; pend_level_i = pend; cur_level_i = cur; level_mask_i = msk;
    intset_i = st; inten_i = en; ps_i = ps; pc_i = pc; vecbase_i = vb; has_depc_i = hd;
    tk = model_take(rq, pend, cur, msk, st, en);
    m_taken = tk;
    if (tk) begin
      if (pend > 3'd1) begin
        m_epc[pend] = pc;
        m_eps[pend] = ps;
        m_ps  = {ps[31:5], 1'b1, 1'b0, pend};
        m_pc  = vb + 32'(pend) * 32'h40;
        m_cls = 3'd1;
      end else begin
        m_cause = 8'd4;
        m_ps    = ps | 32'h10;
        if (ps[4]) begin
          m_cls = 3'd4;
          m_pc  = vb + 32'h3C0;
          if (hd) m_depc = pc;
          else    m_epc[1] = pc;
        end else begin
          m_epc[1] = pc;
          m_cls = ps[5] ? 3'd3 : 3'd2;
          m_pc  = vb + (ps[5] ? 32'h340 : 32'h300);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    compare_all(tag);
  endtask

  function automatic logic [NL*NI-1:0] one_level(input int l, input logic [NI-1:0] m);
    logic [NL*NI-1:0] v;
    v = '0;
    v[(l-1)*NI +: NI] = m;
    return v;
  endfunction

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NL*NI-1:0] full;
    void'($urandom(32'd1357));
    full = '1;
    rst_n = 1'b0; req_i = 1'b0; pend_level_i = '0; cur_level_i = '0;
    level_mask_i = '0; intset_i = '0; inten_i = '0; ps_i = '0; pc_i = '0;
    vecbase_i = '0; has_depc_i = 1'b0;
    m_ps = '0; m_pc = '0; m_depc = '0; m_cls = '0; m_cause = '0; m_taken = 1'b0;
    for (int l = 1; l <= NL; l++) m_epc[l] = '0;
    for (int l = 2; l <= NL; l++) m_eps[l] = '0;
    repeat (3) @(negedge clk);
    compare_all("reset R3");
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R4 R9 high level taken
    do_req("R5 lvl3", 1'b1, 3'd3, 3'd1, one_level(3, 16'h0004), 16'h0004, 16'h0004,
           32'h0000_0021, 32'h1000_0100, 32'h8000_0000, 1'b0);
    // R1 equal level not taken
    do_req("R1 equal", 1'b1, 3'd3, 3'd3, full, 16'hFFFF, 16'hFFFF,
           32'h0, 32'h1111_0000, 32'h8000_0000, 1'b0);
    // R1 level above NLEVEL not taken
    do_req("R1 over", 1'b1, 3'd7, 3'd0, full, 16'hFFFF, 16'hFFFF,
           32'h0, 32'h2222_0000, 32'h8000_0000, 1'b0);
    // R1 top level taken
    do_req("R1 top", 1'b1, 3'd6, 3'd5, one_level(6, 16'h8000), 16'h8000, 16'h8000,
           32'h0000_0005, 32'h3333_0000, 32'h9000_0000, 1'b0);
    // R1 mask mismatch (other level holds the bit)
    do_req("R1 mask", 1'b1, 3'd4, 3'd0, one_level(5, 16'h0010), 16'h0010, 16'h0010,
           32'h0, 32'h4444_0000, 32'h8000_0000, 1'b0);
    // R1 enable clear
    do_req("R1 enable", 1'b1, 3'd2, 3'd0, full, 16'h00F0, 16'h000F,
           32'h0, 32'h5555_0000, 32'h8000_0000, 1'b0);
    // R2 no request with everything else valid
    do_req("R2 noreq", 1'b0, 3'd2, 3'd0, full, 16'hFFFF, 16'hFFFF,
           32'h0, 32'h6666_0000, 32'h8000_0000, 1'b1);
    // R8 kernel
    do_req("R8 kernel", 1'b1, 3'd1, 3'd0, full, 16'h0001, 16'h0001,
           32'h0000_0000, 32'h7000_0010, 32'hA000_0000, 1'b0);
    // R8 user
    do_req("R8 user", 1'b1, 3'd1, 3'd0, full, 16'h0002, 16'h0002,
           32'h0000_0020, 32'h7000_0020, 32'hA000_0000, 1'b1);
    // R7 double with depc
    do_req("R7 dbl depc", 1'b1, 3'd1, 3'd0, full, 16'h0004, 16'h0004,
           32'h0000_0030, 32'h7000_0030, 32'hB000_0000, 1'b1);
    // R7 double without depc
    do_req("R7 dbl epc1", 1'b1, 3'd1, 3'd0, full, 16'h0008, 16'h0008,
           32'h0000_0010, 32'h7000_0040, 32'hB000_0000, 1'b0);
    // R6 level 1 keeps level field
    do_req("R6 keep lvl", 1'b1, 3'd1, 3'd0, full, 16'h0100, 16'h0100,
           32'hF0F0_0020, 32'h7000_0050, 32'hC000_0000, 1'b0);

    // random stimulus
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  pd, cu;
      logic [NL*NI-1:0] mk;
      logic [31:0] ps;
      pd = 3'($urandom_range(0, 7));
      cu = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
      for (int l = 0; l < NL; l++) mk[l*NI +: NI] = 16'($urandom);
      ps = $urandom;
      ps[3:0] = {1'b0, cu};
      do_req("RND R1", ($urandom_range(0, 7) != 0), pd, cu, mk,
             16'($urandom), 16'($urandom), ps, $urandom, $urandom & 32'hFFFF_F000,
             1'($urandom));
      if ($urandom_range(0, 5) == 0) begin
        m_taken = 1'b0;
        @(negedge clk);
        compare_all("RND idle R2");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule